// File: doc/BRIEF.md
# Register-Immediate Integer Execute Unit

This block is the combinational execute stage of a small 32-bit RISC core. Each cycle it receives the decoded instruction fields of one instruction: the 6-bit major opcode, the 6-bit function code, the two register operands and the 16-bit immediate. From these it produces a 32-bit result and a flag that says whether the opcode and function pair is one this unit executes. The register file, the data memory, overflow traps and every control-transfer instruction belong to other blocks.

The unit has no stream interface and no state. Its inputs are plain instruction fields, and its outputs settle within the same cycle. For that reason no valid/ready handshake is needed and no back-pressure applies. An upstream pipeline register holds the fields, and a downstream register captures the result.

Two details decide how the immediate is used. Arithmetic, compare and address forms sign-extend it. Logical forms zero-extend it. The upper-immediate load places the constant in the high half with zeros below. For word load and word store, the result is the effective address.

Top module: `rix_exec`

## Requirements
- R1: With opcode 0, function 32 gives src_a + src_b and function 34 gives src_a - src_b, both wrapping modulo 2^32 with no trap.
- R2: With opcode 0, functions 36, 37, 38 and 39 give bitwise AND, OR, XOR and NOR of src_a and src_b. NOR of two zero operands gives 0xFFFFFFFF.
- R3: With opcode 0 and function 42, the result is 1 when src_a is less than src_b as signed two's-complement values, and 0 otherwise.
- R4: Opcode 8 gives src_a plus the sign-extended immediate (range -32768 to 32767), wrapping modulo 2^32.
- R5: Opcode 10 gives 1 when src_a is signed-less-than the sign-extended immediate, and 0 otherwise.
- R6: Opcodes 12, 13 and 14 give AND, OR and XOR of src_a with the immediate zero-extended to 32 bits.
- R7: Opcode 15 gives the immediate in bits 31:16 and zeros in bits 15:0, whatever src_a holds.
- R8: Opcodes 35 (word load) and 43 (word store) give the address src_a plus the sign-extended immediate.
- R9: For every nonzero supported opcode, src_b and the function field have no effect on the result.
- R10: Any opcode/function pair outside R1–R8 drives result_vld low and result to zero. Every pair inside them drives result_vld high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opc_i | input | 6 | Major opcode field |
| fn_i | input | 6 | Function field, used only when opc_i is 0 |
| src_a_i | input | 32 | First register operand (base for address forms) |
| src_b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Computed result or effective address |
| result_vld_o | output | 1 | High when the pair is supported |

## Verification
The bench builds the unit with its default widths: a 32-bit datapath and a 16-bit immediate. At these widths the opcode map matches the requirements exactly. The immediate corners 0x7FFF, 0x8000 and 0xFFFF then fall on the boundary between sign and zero extension, and the 32-bit wrap and signed-compare edges can be reached. Randomly chosen operands are applied under every supported pair and under arbitrary raw fields, which also reach the unsupported function codes inside opcode 0.

// File: rtl/rix_pkg.sv
package rix_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'd10;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'd13;
  localparam logic [OPC_W-1:0] OPC_XORI = 6'd14;
  localparam logic [OPC_W-1:0] OPC_LUI  = 6'd15;
  localparam logic [OPC_W-1:0] OPC_LDW  = 6'd35;
  localparam logic [OPC_W-1:0] OPC_STW  = 6'd43;

  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_XOR = 6'd38;
  localparam logic [FN_W-1:0] FN_NOR = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR, K_SLT, K_PASSB
  } alu_kind_e;

  typedef enum logic [1:0] {
    IMM_SIGN, IMM_ZERO, IMM_HIGH
  } imm_mode_e;

  typedef struct packed {
    alu_kind_e kind;
    logic      use_imm;
    imm_mode_e imm_mode;
    logic      vld;
  } dec_t;

endpackage

// File: rtl/rix_decode.sv
module rix_decode
  import rix_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [FN_W-1:0]  fn_i,
  output dec_t             dec_o
);

  dec_t d;

  always_comb begin
    d.kind     = K_NONE;
    d.use_imm  = 1'b1;
    d.imm_mode = IMM_SIGN;
    d.vld      = 1'b1;
    unique case (opc_i)
      OPC_REG: begin
        d.use_imm = 1'b0;
        case (fn_i)
          FN_ADD:  d.kind = K_ADD;
          FN_SUB:  d.kind = K_SUB;
          FN_AND:  d.kind = K_AND;
          FN_OR:   d.kind = K_OR;
          FN_XOR:  d.kind = K_XOR;
          FN_NOR:  d.kind = K_NOR;
          FN_SLT:  d.kind = K_SLT;
          default: d.vld  = 1'b0;
        endcase
      end
      OPC_ADDI: d.kind = K_ADD;
      OPC_SLTI: d.kind = K_SLT;
      OPC_ANDI: begin d.kind = K_AND; d.imm_mode = IMM_ZERO; end
      OPC_ORI:  begin d.kind = K_OR;  d.imm_mode = IMM_ZERO; end
      OPC_XORI: begin d.kind = K_XOR; d.imm_mode = IMM_ZERO; end
      OPC_LUI:  begin d.kind = K_PASSB; d.imm_mode = IMM_HIGH; end
      OPC_LDW,
      OPC_STW:  d.kind = K_ADD;
      default: begin
        d.vld     = 1'b0;
        d.use_imm = 1'b0;
      end
    endcase
    if (!d.vld) d.kind = K_NONE;
    dec_o = d;
  end

  always_comb begin
    // R9
    imm_only_nonzero_opc_chk: assert (!dec_o.use_imm || opc_i != OPC_REG)
      else $error("immediate operand selected under register opcode");
    // R10
    kind_matches_vld_chk: assert (dec_o.vld == (dec_o.kind != K_NONE))
      else $error("decode valid disagrees with operation kind");
  end

endmodule

// File: rtl/rix_opsel.sv
module rix_opsel
  import rix_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  imm_mode_e         imm_mode_i,
  output logic [DATA_W-1:0] opnd_b_o
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] ext_imm;

  always_comb begin
    unique case (imm_mode_i)
      IMM_ZERO: ext_imm = {{PAD_W{1'b0}}, imm_i};
      IMM_HIGH: ext_imm = {imm_i, {PAD_W{1'b0}}};
      default:  ext_imm = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
    endcase
    opnd_b_o = use_imm_i ? ext_imm : src_b_i;
  end

endmodule

// File: rtl/rix_alu.sv
module rix_alu
  import rix_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_kind_e         kind_i,
  output logic [DATA_W-1:0] y_o
);

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] diff;
  logic              lt;

  always_comb begin
    sum  = a_i + b_i;
    diff = a_i - b_i;
    lt   = $signed(a_i) < $signed(b_i);
    unique case (kind_i)
      K_ADD:   y_o = sum;
      K_SUB:   y_o = diff;
      K_AND:   y_o = a_i & b_i;
      K_OR:    y_o = a_i | b_i;
      K_XOR:   y_o = a_i ^ b_i;
      K_NOR:   y_o = ~(a_i | b_i);
      K_SLT:   y_o = {{(DATA_W-1){1'b0}}, lt};
      K_PASSB: y_o = b_i;
      default: y_o = '0;
    endcase
  end

  always_comb begin
    // R3
    slt_bool_chk: assert (kind_i != K_SLT || y_o <= 1)
      else $error("compare result wider than one bit");
  end

endmodule

// File: rtl/rix_exec.sv
module rix_exec
  import rix_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [FN_W-1:0]   fn_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_vld_o
);

  localparam int HI_W = DATA_W - IMM_W + 1;

  dec_t              dec;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_y;

  rix_decode u_dec (
    .opc_i (opc_i),
    .fn_i  (fn_i),
    .dec_o (dec)
  );

  rix_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .src_b_i    (src_b_i),
    .imm_i      (imm_i),
    .use_imm_i  (dec.use_imm),
    .imm_mode_i (dec.imm_mode),
    .opnd_b_o   (opnd_b)
  );

  rix_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i    (src_a_i),
    .b_i    (opnd_b),
    .kind_i (dec.kind),
    .y_o    (alu_y)
  );

  assign result_o     = alu_y;
  assign result_vld_o = dec.vld;

  always_comb begin
    // R10
    unsupported_zero_chk: assert (result_vld_o || result_o == '0)
      else $error("unsupported pair produced nonzero result");
    // R9
    reg_operand_pass_chk: assert (dec.use_imm || opnd_b == src_b_i)
      else $error("register operand altered");
    // R4
    imm_sign_chk: assert (!(dec.use_imm && dec.imm_mode == IMM_SIGN) ||
                          (opnd_b[IMM_W-1:0] == imm_i &&
                           ($countones(opnd_b[DATA_W-1:IMM_W-1]) == 0 ||
                            $countones(opnd_b[DATA_W-1:IMM_W-1]) == HI_W)))
      else $error("sign extension broken");
    // R6
    imm_zero_chk: assert (!(dec.use_imm && dec.imm_mode == IMM_ZERO) ||
                          (opnd_b[IMM_W-1:0] == imm_i &&
                           $countones(opnd_b[DATA_W-1:IMM_W]) == 0))
      else $error("zero extension broken");
    // R7
    imm_high_chk: assert (!(dec.use_imm && dec.imm_mode == IMM_HIGH) ||
                          (opnd_b[DATA_W-1:DATA_W-IMM_W] == imm_i &&
                           $countones(opnd_b[DATA_W-IMM_W-1:0]) == 0))
      else $error("upper placement broken");
  end

endmodule

// File: tb/sim_rix_exec.sv
module sim_rix_exec;

  logic        clk = 1'b0;
  logic [5:0]  opc;
  logic [5:0]  fn;
  logic [31:0] a;
  logic [31:0] b;
  logic [15:0] imm;
  logic [31:0] res;
  logic        vld;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rix_exec u0 (
    .opc_i        (opc),
    .fn_i         (fn),
    .src_a_i      (a),
    .src_b_i      (b),
    .imm_i        (imm),
    .result_o     (res),
    .result_vld_o (vld)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL R10 watchdog actual=%0d expected<50000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic void model(input logic [5:0] o, input logic [5:0] f,
                                input logic [31:0] x, input logic [31:0] y,
                                input logic [15:0] im,
                                output logic [31:0] r, output logic v);
    logic [31:0] sx;
    logic [31:0] zx;
    sx = {{16{im[15]}}, im};
    zx = {16'h0, im};
    v = 1'b1;
    r = 32'h0;
    case (o)
      6'd0: case (f)
        6'd32: r = x + y;
        6'd34: r = x - y;
        6'd36: r = x & y;
        6'd37: r = x | y;
        6'd38: r = x ^ y;
        6'd39: r = ~(x | y);
        6'd42: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
        default: v = 1'b0;
      endcase
      6'd8:  r = x + sx;
      6'd10: r = ($signed(x) < $signed(sx)) ? 32'd1 : 32'd0;
      6'd12: r = x & zx;
      6'd13: r = x | zx;
      6'd14: r = x ^ zx;
      6'd15: r = {im, 16'h0};
      6'd35, 6'd43: r = x + sx;
      default: v = 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] o, input logic [5:0] f);
    case (o)
      6'd0: case (f)
        6'd32, 6'd34: return "R1";
        6'd36, 6'd37, 6'd38, 6'd39: return "R2";
        6'd42: return "R3";
        default: return "R10";
      endcase
      6'd8: return "R4";
      6'd10: return "R5";
      6'd12, 6'd13, 6'd14: return "R6";
      6'd15: return "R7";
      6'd35, 6'd43: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [5:0] o, input logic [5:0] f,
                       input logic [31:0] x, input logic [31:0] y,
                       input logic [15:0] im);
    @(negedge clk);
    opc = o; fn = f; a = x; b = y; imm = im;
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic ev);
    total = total + 1;
    if (res !== er || vld !== ev) begin
      bad = bad + 1;
      $display("FAIL %s opc=%0d fn=%0d actual=%h/%b expected=%h/%b",
               tag, opc, fn, res, vld, er, ev);
    end
  endtask

  task automatic run_model(input logic [5:0] o, input logic [5:0] f,
                           input logic [31:0] x, input logic [31:0] y,
                           input logic [15:0] im);
    logic [31:0] er;
    logic        ev;
    apply(o, f, x, y, im);
    model(o, f, x, y, im, er, ev);
    check(tag_of(o, f), er, ev);
  endtask

  function automatic logic [11:0] pick_pair(input int k);
    case (k)
      0: return {6'd0, 6'd32};   1: return {6'd0, 6'd34};
      2: return {6'd0, 6'd36};   3: return {6'd0, 6'd37};
      4: return {6'd0, 6'd38};   5: return {6'd0, 6'd39};
      6: return {6'd0, 6'd42};   7: return {6'd8, 6'd0};
      8: return {6'd10, 6'd0};   9: return {6'd12, 6'd0};
      10: return {6'd13, 6'd0};  11: return {6'd14, 6'd0};
      12: return {6'd15, 6'd0};  13: return {6'd35, 6'd0};
      default: return {6'd43, 6'd0};
    endcase
  endfunction

  initial begin
    logic [31:0] r1;
    int unsigned seed_ret;
    opc = '0; fn = '0; a = '0; b = '0; imm = '0;
    seed_ret = $urandom(32'd20240611);
    #1;
    // R10: idle fields opcode 0 / function 0 are unsupported
    check("R10", 32'h0, 1'b0);

    // R2: nor of zeros gives all ones
    apply(6'd0, 6'd39, 32'h0, 32'h0, 16'h0);
    check("R2", 32'hFFFF_FFFF, 1'b1);
    // R1: wrap on add and sub
    apply(6'd0, 6'd32, 32'hFFFF_FFFF, 32'h1, 16'h0);
    check("R1", 32'h0, 1'b1);
    apply(6'd0, 6'd34, 32'h0, 32'h1, 16'h0);
    check("R1", 32'hFFFF_FFFF, 1'b1);
    // R3: signed compare both directions
    apply(6'd0, 6'd42, 32'hFFFF_FFFF, 32'h1, 16'h0);
    check("R3", 32'h1, 1'b1);
    apply(6'd0, 6'd42, 32'h1, 32'hFFFF_FFFF, 16'h0);
    check("R3", 32'h0, 1'b1);
    apply(6'd0, 6'd42, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0);
    check("R3", 32'h1, 1'b1);
    // R4: negative immediate, and most negative
    apply(6'd8, 6'd0, 32'd5, 32'h0, 16'hFFFF);
    check("R4", 32'd4, 1'b1);
    apply(6'd8, 6'd0, 32'h0, 32'h0, 16'h8000);
    check("R4", 32'hFFFF_8000, 1'b1);
    apply(6'd8, 6'd0, 32'h0, 32'h0, 16'h7FFF);
    check("R4", 32'h0000_7FFF, 1'b1);
    // R5: compare against sign-extended immediate
    apply(6'd10, 6'd0, 32'hFFFF_FFFB, 32'h0, 16'hFFFE);
    check("R5", 32'h1, 1'b1);
    apply(6'd10, 6'd0, 32'h0, 32'h0, 16'h8000);
    check("R5", 32'h0, 1'b1);
    // R6: zero extension
    apply(6'd12, 6'd0, 32'hFFFF_FFFF, 32'h0, 16'h8000);
    check("R6", 32'h0000_8000, 1'b1);
    apply(6'd13, 6'd0, 32'h1234_0000, 32'h0, 16'hFFFF);
    check("R6", 32'h1234_FFFF, 1'b1);
    apply(6'd14, 6'd0, 32'hFFFF_FFFF, 32'h0, 16'h00FF);
    check("R6", 32'hFFFF_FF00, 1'b1);
    // R7: upper half load ignores src_a
    apply(6'd15, 6'd0, 32'hDEAD_BEEF, 32'h0, 16'h2110);
    check("R7", 32'h2110_0000, 1'b1);
    // R8: load and store addresses
    apply(6'd35, 6'd0, 32'h0000_1000, 32'h0, 16'hFFFC);
    check("R8", 32'h0000_0FFC, 1'b1);
    apply(6'd43, 6'd0, 32'h0000_1000, 32'h0, 16'd40);
    check("R8", 32'h0000_1028, 1'b1);
    // R9: src_b and fn have no effect under immediate opcodes
    apply(6'd8, 6'd0, 32'd100, 32'h0, 16'd7);
    r1 = res;
    apply(6'd8, 6'd34, 32'd100, 32'hFFFF_FFFF, 16'd7);
    check("R9", r1, 1'b1);
    apply(6'd13, 6'd42, 32'h0, 32'h5555_5555, 16'h00F0);
    check("R9", 32'h0000_00F0, 1'b1);
    // R10: unsupported pairs
    apply(6'd0, 6'd33, 32'h1, 32'h2, 16'h3);
    check("R10", 32'h0, 1'b0);
    apply(6'd9, 6'd32, 32'h1, 32'h2, 16'h3);
    check("R10", 32'h0, 1'b0);
    apply(6'd2, 6'd0, 32'hFFFF_FFFF, 32'h2, 16'hFFFF);
    check("R10", 32'h0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [11:0] pr;
      logic [5:0]  o;
      logic [5:0]  f;
      if ($urandom_range(0, 4) == 0) begin
        o = 6'($urandom);
        f = 6'($urandom);
        if ($urandom_range(0, 1) == 0) o = 6'd0;
      end else begin
        pr = pick_pair(int'($urandom_range(0, 14)));
        o = pr[11:6];
        f = (o == 6'd0) ? pr[5:0] : 6'($urandom);
      end
      run_model(o, f, $urandom, $urandom, 16'($urandom));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule